// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation analogue-to-digital converter. A single-cycle start request opens a conversion. The block then drives a trial code to an external DAC and reads back one comparator bit on each clock. It runs a binary search that settles one result bit per cycle, beginning at the most significant bit. When the search ends it publishes the code together with a one-cycle done strobe.

When built with the extra-LSB option, the block adds one more cycle once the n-bit search has finished. In that cycle it holds the final code on the DAC and raises a half-step request, which asks the DAC to add half an LSB. The comparator answer in that cycle becomes an extra least-significant result bit. This gives an (n+1)-bit result from an n-bit search.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While reset (`rst_n` low, sampled on the clock) is applied, the trial code, the half-step request, the result, `busy_o` and `done_o` are all zero. A reset during a conversion abandons it and returns the block to idle.
- R2: A start request seen while idle makes the next cycle show a trial code with only the most significant bit set, and raises `busy_o`.
- R3: On each search cycle the bit under test is kept when `cmp_i` is 1 and cleared when it is 0. If a lower bit remains, that bit is then set as the new trial. `cmp_i` = 1 means the input is at or above the DAC level.
- R4: With the option off, `done_o` is high in the cycle after the n-th decision edge that follows the accepted start. With the option on, `done_o` comes one cycle later.
- R5: With the option on, the cycle after the n-th decision shows the final n-bit code with `dac_half_o` high. The result is then {code, cmp_i sampled in that cycle}.
- R6: `done_o` is high for exactly one cycle. `result_o` changes only when a conversion completes and holds its value in between.
- R7: A start request while `busy_o` is high is ignored. The search continues unchanged and produces only one result.
- R8: While the block is idle, the trial code is zero and `dac_half_o` is low.
- R9: With an ideal comparator, the result equals the input level rounded down to the result resolution: n bits with the option off, n+1 bits with it on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Conversion request, honoured only when idle |
| cmp_i | input | 1 | Comparator decision: 1 = input at or above DAC level |
| dac_code_o | output | DATA_W | Trial code to the DAC |
| dac_half_o | output | 1 | Asks the DAC for an extra half-LSB offset (extra-bit phase) |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-cycle strobe: result is new |
| result_o | output | DATA_W+EXTRA_LSB | Last conversion result |

## Verification
The hardest situations to reach from the ports are a start pulse that arrives in the middle of a search and a reset that cuts a search short. The stimulus places a second start pulse at a chosen decision index, on an input whose trial sequence differs visibly from a fresh start. It also drops reset a few cycles into a conversion. For the half-step cycle, odd and even input levels are driven so that both values of the extra bit appear, including the all-zero and full-scale extremes.

// File: rtl/sar_pkg.sv
// Package: shared types for the successive-approximation controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_pkg;

    // Sequencer phases: waiting, binary search, optional half-step decision.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_HALF   = 2'd2
    } sar_state_e;

endpackage

// File: rtl/sar_seq.sv
// Module: sar_seq
// Sequences one conversion. Accepts a start only when idle, walks the bit
// index from the MSB down to zero (one decision per clock), then either
// ends or enters the half-step phase when EXTRA_LSB is set.
// Assumes: DATA_W >= 2, IDX_W wide enough to hold DATA_W-1.
module sar_seq
    import sar_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int EXTRA_LSB = 1,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output sar_state_e       state_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             load_o,
    output logic             step_o,
    output logic             finish_o
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);
    localparam sar_state_e AFTER_LAST = (EXTRA_LSB != 0) ? ST_HALF : ST_IDLE;

    sar_state_e       state;
    logic [IDX_W-1:0] idx;

    // Phase and bit-index register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state <= ST_SEARCH;
                        idx   <= TOP_IDX;
                    end
                end
                ST_SEARCH: begin
                    if (idx == '0) begin
                        state <= AFTER_LAST;
                    end else begin
                        idx <= idx - 1'b1;
                    end
                end
                ST_HALF: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Control strobes for the trial and result registers.
    always_comb begin
        load_o = (state == ST_IDLE) && start_i;
        step_o = (state == ST_SEARCH);
    end

    // Finish point depends on whether the extra bit is taken.
    generate
        if (EXTRA_LSB != 0) begin : g_fin_half
            assign finish_o = (state == ST_HALF);
        end else begin : g_fin_search
            assign finish_o = (state == ST_SEARCH) && (idx == '0);
        end
    endgenerate

    assign state_o = state;
    assign idx_o   = idx;

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && idx != '0) |=>
        (state == ST_SEARCH && idx == IDX_W'($past(idx) - 1'b1)));

    // R2
    load_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (state == ST_SEARCH && idx == TOP_IDX));

endmodule

// File: rtl/sar_trial_reg.sv
// Module: sar_trial_reg
// Holds the trial code. On load it presets only the MSB; on each search
// step it applies the comparator decision to the bit under test and then
// sets the next lower bit. The decided code (the decision applied, no new
// trial bit) is also exposed for result capture.
// Assumes: load_i and finish_i are never high together.
module sar_trial_reg #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              finish_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              cmp_i,
    output logic [DATA_W-1:0] trial_o,
    output logic [DATA_W-1:0] decided_o
);

    localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] trial;
    logic [DATA_W-1:0] nxt;

    // Apply the comparator verdict to the bit under test.
    always_comb begin
        decided_o = trial;
        if (step_i && !cmp_i) begin
            decided_o[idx_i] = 1'b0;
        end
    end

    // Propose the next lower bit as the new trial.
    always_comb begin
        nxt = decided_o;
        if (step_i && (idx_i != '0)) begin
            nxt[IDX_W'(idx_i - 1'b1)] = 1'b1;
        end
    end

    // Trial register: preset, advance, or clear at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial <= '0;
        end else if (load_i) begin
            trial <= MSB_ONLY;
        end else if (finish_i) begin
            trial <= '0;
        end else begin
            trial <= nxt;
        end
    end

    assign trial_o = trial;

    // R3
    keep_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && cmp_i && !finish_i) |=> trial[$past(idx_i)]);

    // R3
    clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cmp_i && !finish_i) |=> !trial[$past(idx_i)]);

    // R2
    preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (trial == MSB_ONLY));

endmodule

// File: rtl/sar_result_reg.sv
// Module: sar_result_reg
// Captures the finished code and raises a one-cycle done strobe.
// Holds the result until the next completion.
// Assumes: finish_i is a single-cycle pulse per conversion.
module sar_result_reg #(
    parameter int RES_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             finish_i,
    input  logic [RES_W-1:0] res_i,
    output logic [RES_W-1:0] result_o,
    output logic             done_o
);

    // Result capture and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= finish_i;
            if (finish_i) begin
                result_o <= res_i;
            end
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !finish_i |=> $stable(result_o));

endmodule

// File: rtl/sar_conv_ctrl.sv
// Module: sar_conv_ctrl (top)
// Successive-approximation conversion controller: sequencer, trial
// register and result register. With EXTRA_LSB set, one half-step cycle
// follows the search and its comparator verdict becomes the result LSB.
// Assumes: an external DAC follows dac_code_o (plus half an LSB when
// dac_half_o is high) and cmp_i reflects that level in the same cycle.
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int EXTRA_LSB = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        cmp_i,
    output logic [DATA_W-1:0]           dac_code_o,
    output logic                        dac_half_o,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [DATA_W+EXTRA_LSB-1:0] result_o
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int RES_W = DATA_W + EXTRA_LSB;
    localparam int LEN   = DATA_W + EXTRA_LSB;
    localparam int CNT_W = $clog2(LEN + 2);

    sar_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic              load;
    logic              step;
    logic              finish;
    logic [DATA_W-1:0] trial;
    logic [DATA_W-1:0] decided;
    logic [RES_W-1:0]  res_in;

    sar_seq #(
        .DATA_W    (DATA_W),
        .EXTRA_LSB (EXTRA_LSB),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .state_o  (state),
        .idx_o    (idx),
        .load_o   (load),
        .step_o   (step),
        .finish_o (finish)
    );

    sar_trial_reg #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_trial (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (step),
        .finish_i  (finish),
        .idx_i     (idx),
        .cmp_i     (cmp_i),
        .trial_o   (trial),
        .decided_o (decided)
    );

    // Result word: decided code, with the half-step verdict appended if enabled.
    generate
        if (EXTRA_LSB != 0) begin : g_res_ext
            assign res_in = {decided, cmp_i};
        end else begin : g_res_plain
            assign res_in = decided;
        end
    endgenerate

    sar_result_reg #(
        .RES_W (RES_W)
    ) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .finish_i (finish),
        .res_i    (res_in),
        .result_o (result_o),
        .done_o   (done_o)
    );

    assign dac_code_o = trial;
    assign dac_half_o = (state == ST_HALF);
    assign busy_o     = (state != ST_IDLE);

    // Cycles spent busy since the accepted start (checking aid only).
    logic [CNT_W-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (load) begin
            run_cnt <= '0;
        end else if (busy_o) begin
            run_cnt <= run_cnt + CNT_W'(1);
        end
    end

    // R4
    conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_cnt == CNT_W'(LEN)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (dac_code_o == '0 && !dac_half_o));

    // R5
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_half_o |-> (dac_code_o == $past(decided)));

endmodule

// File: tb/sim_sar_conv_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: u0 takes the extra bit, u1 does not. Each has an ideal
// threshold comparator driven from the 9-bit input level vin.
module sim_sar_conv_ctrl;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [DW:0]   vin;

    logic [DW-1:0] code0, code1;
    logic          half0, half1, busy0, busy1, done0, done1;
    logic [DW:0]   result0;
    logic [DW-1:0] result1;
    logic          cmp0, cmp1;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW:0]   q0[$];
    logic [DW-1:0] q1[$];
    logic [DW:0]   last_res0 = '0;
    logic [DW-1:0] last_res1 = '0;
    logic          prev_done0 = 1'b0;

    always #4 clk = ~clk;

    assign cmp0 = (vin >= {code0, half0});
    assign cmp1 = (vin[DW:1] >= code1);

    sar_conv_ctrl #(.DATA_W(DW), .EXTRA_LSB(1)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp0),
        .dac_code_o(code0), .dac_half_o(half0), .busy_o(busy0),
        .done_o(done0), .result_o(result0)
    );

    sar_conv_ctrl #(.DATA_W(DW), .EXTRA_LSB(0)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp1),
        .dac_code_o(code1), .dac_half_o(half1), .busy_o(busy1),
        .done_o(done1), .result_o(result1)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Monitor: pops expected results as done strobes appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done0) begin
                if (q0.size() == 0) begin
                    chk(1'b0, "R7 extra result u0", 32'(result0), 32'hFFFF);
                end else begin
                    logic [DW:0] e0;
                    e0 = q0.pop_front();
                    chk(result0 == e0, "R9/R5 result u0", 32'(result0), 32'(e0));
                end
                last_res0 = result0;
            end
            if (done1) begin
                if (q1.size() == 0) begin
                    chk(1'b0, "R7 extra result u1", 32'(result1), 32'hFFFF);
                end else begin
                    logic [DW-1:0] e1;
                    e1 = q1.pop_front();
                    chk(result1 == e1, "R9 result u1", 32'(result1), 32'(e1));
                end
                last_res1 = result1;
            end
            if (done0 && prev_done0) begin
                chk(1'b0, "R6 done width", 32'd2, 32'd1);
            end
            prev_done0 = done0;
        end
    end

    // Driver: one conversion, optional spurious start at decision index spur.
    task automatic run_conv(input logic [DW:0] v, input int spur);
        logic [DW-1:0] hi;
        logic [DW-1:0] ex;
        hi = v[DW:1];
        vin = v;
        q0.push_back(v);
        q1.push_back(hi);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        ex = 8'h80;
        chk(busy0 && busy1 && code0 == 8'h80, "R2 first trial", 32'(code0), 32'h80);
        for (int k = DW - 1; k >= 0; k--) begin
            chk(code0 == ex && code1 == ex, "R3 trial code", 32'(code0), 32'(ex));
            chk(result0 == last_res0 && result1 == last_res1, "R6 hold",
                32'(result0), 32'(last_res0));
            chk(!done0 && !done1, "R4 early done", 32'({done0, done1}), 32'd0);
            if (hi < ex) ex[k] = 1'b0;
            if (k > 0) ex[k-1] = 1'b1;
            start = (k == spur);
            @(negedge clk);
            start = 1'b0;
        end
        chk(done1 && !done0, "R4 latency", 32'({done1, done0}), 32'b10);
        chk(half0 && code0 == hi && busy0, "R5 half step", 32'(code0), 32'(hi));
        @(negedge clk);
        chk(done0, "R4 latency extra", 32'(done0), 32'd1);
        chk(code0 == 0 && !half0 && !busy0 && code1 == 0, "R8 idle", 32'(code0), 32'd0);
        @(negedge clk);
        chk(!done0 && !done1, "R6 single pulse", 32'({done0, done1}), 32'd0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Main sequence.
    initial begin
        logic [DW:0] lf;
        rst_n = 1'b0;
        start = 1'b0;
        vin   = '0;
        repeat (3) @(negedge clk);
        chk(code0 == 0 && !half0 && result0 == 0 && !done0 && !busy0 && result1 == 0,
            "R1 reset", 32'(result0), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_conv(9'h000, -1);
        run_conv(9'h1FF, -1);
        run_conv(9'h100, -1);
        run_conv(9'h0FF, -1);
        run_conv(9'h001, -1);
        run_conv(9'h155, -1);
        run_conv(9'h0AA, 4);   // R7: start during search at index 4
        run_conv(9'h033, 0);   // R7: start on the last decision

        // Idle gap: result must hold, DAC quiet (R6, R8).
        repeat (5) @(negedge clk);
        chk(result0 == 9'h033 && code0 == 0 && !half0, "R6 idle hold",
            32'(result0), 32'h33);

        lf = 9'h1A5;
        for (int i = 0; i < 20; i++) begin
            lf = {lf[DW-1:0], lf[DW] ^ lf[4]};
            run_conv(lf, -1);
        end

        // R1: reset mid-conversion returns to idle.
        vin = 9'h0F0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy0 && !busy1 && code0 == 0 && result0 == 0 && !done0,
            "R1 abort", 32'(code0), 32'd0);
        rst_n = 1'b1;
        last_res0 = '0;
        last_res1 = '0;
        @(negedge clk);
        run_conv(9'h0F0, -1);

        repeat (4) @(negedge clk);
        chk(q0.size() == 0 && q1.size() == 0, "R4 all results seen",
            32'(q0.size() + q1.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule